// File: doc/BRIEF.md
# Two-Dimensional Nested Page Walker

This block translates a guest virtual address into a host physical address for a virtualized system. The guest page table has four levels, and every pointer in it is a guest physical address. Before the walker can read a guest entry it must turn that entry's guest physical address into a host physical address with a complete four-level walk of the host (nested) page table. The guest physical page found at the bottom of the guest table is then translated one last time to give the result. With no cached help a translation costs 24 reads on the single memory read port: five nested walks of four reads each, plus four guest reads.

A small fully associative nested TLB remembers guest-page to host-page results. A hit skips the nested walk it stands for. An invalidate-all input empties it. The walker accepts one request at a time. It answers with a one-cycle response carrying either the host physical address or a fault. A fault names the dimension (guest or nested) and the level whose entry had its valid bit clear.

The controller is a single state machine with seven states. IDLE accepts a request (go). XLATE forms the guest physical address for the current step and probes the nested TLB: a hit moves to GREQ, or to RESP for the final step; a miss starts a nested walk in NREQ. NREQ issues a nested read and moves to NWAIT on acceptance. NWAIT takes the entry: an invalid entry moves to RESP (nested fault), a valid upper-level entry goes back to NREQ, and a valid last-level entry goes to GREQ, or to RESP for the final step. GREQ issues the guest entry read and moves to GWAIT. GWAIT either faults to RESP or advances the guest step and returns to XLATE. RESP drives the response for one cycle and returns to IDLE.

Top module: `nested_walker`

## Requirements
- R1: Out of reset, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0.
- R2: A walk that hits nothing in the nested TLB issues exactly 24 reads. The order is: for each of the five steps, four nested reads from the top level down, then the guest entry read. The final step has no guest read.
- R3: The guest entry address for step s (s = 0 to 3) is the current guest base page (starting with guest_root bits 47:12), then the 9-bit gVA index for guest level 3-s, then three zero bits. Level 3 uses gVA bits 47:39 and level 0 uses bits 20:12. The final step's guest physical address is the guest base page followed by gVA bits 11:0.
- R4: A nested walk starts from host_root bits 47:12. Nested read address = table base page, then the 9-bit index of the guest physical address for the current nested level (level 3 uses bits 47:39), then three zero bits. The next base is entry bits 47:12. The guest read address is the translated host page followed by the guest physical address bits 11:0.
- R5: Entries are 64 bits: bit 0 is valid and bits 47:12 hold the next page. On success rsp_hpa is the host page from the final translation followed by gVA bits 11:0, and rsp_fault is 0.
- R6: A read entry with bit 0 clear ends the walk at once with no further read. It returns rsp_fault = 1, rsp_hpa = 0, rsp_fault_nested = 1 for a nested entry or 0 for a guest entry, and rsp_fault_level = 3 for the top level down to 0 for the last level.
- R7: A completed nested walk is stored in the nested TLB. An immediate repeat of the same translation, or one differing only in gVA bits 11:0, reads only the four guest entries.
- R8: A pulse on flush_ntlb empties the nested TLB, so the next walk again costs 24 reads.
- R9: When flush_ntlb is high in the same cycle as a nested TLB fill, the flush wins and the fill is dropped.
- R10: From acceptance until its response, req_ready stays 0. rsp_valid is high for exactly one cycle, after which req_ready is 1.
- R11: While mem_req_valid is high and mem_req_ready is low, the request and its address hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_ntlb | input | 1 | Invalidate every nested TLB entry |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_gva | input | 48 | Guest virtual address |
| guest_root | input | 48 | Guest physical address of the top guest table |
| host_root | input | 48 | Host physical address of the top nested table |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hpa | output | 48 | Translated host physical address (0 on fault) |
| rsp_fault | output | 1 | Walk ended on an invalid entry |
| rsp_fault_nested | output | 1 | 1: fault in nested dimension, 0: guest |
| rsp_fault_level | output | 2 | Faulting level, 3 = top |
| mem_req_valid | output | 1 | Read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 48 | Host physical byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Entry read |

## Verification
The collision of interest is an invalidate-all arriving in the very cycle the last nested entry of a walk returns and the TLB is being filled. The bench's memory model raises flush_ntlb together with the response to the fourth read of a cold walk, which is the fill for the guest top-level page. It then repeats the walk: if the flush won, the repeat costs 8 reads (one nested walk redone plus four guest reads); if the fill survived it costs 4. The remaining translations are judged against an arithmetic page-table model that hashes each read address into an entry. Fault injection is swept over every one of the 24 read positions, both with and without memory back-pressure.

// File: rtl/npw_pkg.sv
package npw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XLATE,
        ST_NREQ,
        ST_NWAIT,
        ST_GREQ,
        ST_GWAIT,
        ST_RESP
    } walk_state_e;

endpackage

// File: rtl/npw_addr.sv
module npw_addr #(
    parameter int PA_W   = 48,
    parameter int VA_W   = 48,
    parameter int PG_W   = 12,
    parameter int IDX_W  = 9,
    parameter int LEVELS = 4,
    localparam int PPN_W  = PA_W - PG_W,
    localparam int STEP_W = $clog2(LEVELS + 1),
    localparam int LVL_W  = $clog2(LEVELS)
) (
    input  logic [VA_W-1:0]   gva,
    input  logic [PPN_W-1:0]  gbase_pg,
    input  logic [STEP_W-1:0] gstep,
    input  logic [PPN_W-1:0]  nbase_pg,
    input  logic [LVL_W-1:0]  nlvl,
    input  logic [PPN_W-1:0]  hpage,
    output logic [PA_W-1:0]   gpa,
    output logic [PA_W-1:0]   nrd_addr,
    output logic [PA_W-1:0]   grd_addr
);

    localparam int ENT_SH = PG_W - IDX_W;

    logic [IDX_W-1:0] gidx [LEVELS];
    logic [IDX_W-1:0] nidx [LEVELS];
    logic [LVL_W-1:0] glvl;

    generate
        for (genvar l = 0; l < LEVELS; l++) begin : g_idx
            assign gidx[l] = gva[PG_W + IDX_W*l +: IDX_W];
            assign nidx[l] = gpa[PG_W + IDX_W*l +: IDX_W];
        end
    endgenerate

    assign glvl = LVL_W'(LEVELS - 1) - gstep[LVL_W-1:0];

    always_comb begin
        if (int'(gstep) == LEVELS) begin
            gpa = {gbase_pg, gva[PG_W-1:0]};
        end else begin
            gpa = {gbase_pg, gidx[glvl], {ENT_SH{1'b0}}};
        end
    end

    assign nrd_addr = {nbase_pg, nidx[nlvl], {ENT_SH{1'b0}}};
    assign grd_addr = {hpage, gpa[PG_W-1:0]};

endmodule

// File: rtl/npw_ntlb.sv
module npw_ntlb #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 36,
    parameter int DATA_W  = 36,
    localparam int PTR_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              hit,
    output logic [DATA_W-1:0] hit_data,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data
);

    logic [ENTRIES-1:0] vld;
    logic [ENTRIES-1:0] hit_vec;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [DATA_W-1:0]  dat_q [ENTRIES];
    logic [PTR_W-1:0]   ptr;

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
            assign hit_vec[e] = vld[e] && (tag_q[e] == lk_tag);
        end
    endgenerate

    always_comb begin
        hit_data = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (hit_vec[e]) hit_data = hit_data | dat_q[e];
        end
        hit = |hit_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            ptr <= '0;
        end else if (flush) begin
            vld <= '0;
        end else if (fill_en) begin
            vld[ptr] <= 1'b1;
            ptr      <= (ptr == PTR_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            tag_q[ptr] <= fill_tag;
            dat_q[ptr] <= fill_data;
        end
    end

    // R7
    ntlb_single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/nested_walker.sv
module nested_walker #(
    parameter int PA_W        = 48,
    parameter int VA_W        = 48,
    parameter int PG_W        = 12,
    parameter int IDX_W       = 9,
    parameter int LEVELS      = 4,
    parameter int ENT_W       = 64,
    parameter int TLB_ENTRIES = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush_ntlb,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [VA_W-1:0]           req_gva,
    input  logic [PA_W-1:0]           guest_root,
    input  logic [PA_W-1:0]           host_root,
    output logic                      rsp_valid,
    output logic [PA_W-1:0]           rsp_hpa,
    output logic                      rsp_fault,
    output logic                      rsp_fault_nested,
    output logic [$clog2(LEVELS)-1:0] rsp_fault_level,
    output logic                      mem_req_valid,
    input  logic                      mem_req_ready,
    output logic [PA_W-1:0]           mem_req_addr,
    input  logic                      mem_rsp_valid,
    input  logic [ENT_W-1:0]          mem_rsp_data
);
    import npw_pkg::*;

    localparam int PPN_W  = PA_W - PG_W;
    localparam int STEP_W = $clog2(LEVELS + 1);
    localparam int LVL_W  = $clog2(LEVELS);
    localparam int MAX_RD = LEVELS * (LEVELS + 1) + LEVELS;
    localparam int RDC_W  = $clog2(MAX_RD + 1);

    walk_state_e state, state_nx;

    logic [VA_W-1:0]   gva_q;
    logic [PPN_W-1:0]  gbase_q;
    logic [PPN_W-1:0]  hroot_q;
    logic [STEP_W-1:0] gstep_q;
    logic [LVL_W-1:0]  nlvl_q;
    logic [PPN_W-1:0]  nbase_q;
    logic [PPN_W-1:0]  hpage_q;
    logic [PA_W-1:0]   hpa_q;
    logic              fault_q;
    logic              fdim_q;
    logic [LVL_W-1:0]  flvl_q;

    logic [PA_W-1:0]   gpa;
    logic [PA_W-1:0]   nrd_addr;
    logic [PA_W-1:0]   grd_addr;
    logic              tlb_hit;
    logic [PPN_W-1:0]  tlb_data;
    logic              tlb_fill;
    logic              ent_ok;
    logic [PPN_W-1:0]  ent_pg;
    logic              last_step;
    logic              unused_bits;

    assign ent_ok      = mem_rsp_data[0];
    assign ent_pg      = mem_rsp_data[PA_W-1:PG_W];
    assign last_step   = (int'(gstep_q) == LEVELS);
    assign unused_bits = ^{mem_rsp_data[ENT_W-1:PA_W], mem_rsp_data[PG_W-1:1]};
    assign tlb_fill    = (state == ST_NWAIT) && mem_rsp_valid && ent_ok && (nlvl_q == '0);

    npw_addr #(
        .PA_W(PA_W), .VA_W(VA_W), .PG_W(PG_W), .IDX_W(IDX_W), .LEVELS(LEVELS)
    ) u_addr (
        .gva      (gva_q),
        .gbase_pg (gbase_q),
        .gstep    (gstep_q),
        .nbase_pg (nbase_q),
        .nlvl     (nlvl_q),
        .hpage    (hpage_q),
        .gpa      (gpa),
        .nrd_addr (nrd_addr),
        .grd_addr (grd_addr)
    );

    npw_ntlb #(
        .ENTRIES(TLB_ENTRIES), .TAG_W(PPN_W), .DATA_W(PPN_W)
    ) u_ntlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_ntlb),
        .lk_tag    (gpa[PA_W-1:PG_W]),
        .hit       (tlb_hit),
        .hit_data  (tlb_data),
        .fill_en   (tlb_fill),
        .fill_tag  (gpa[PA_W-1:PG_W]),
        .fill_data (ent_pg)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_XLATE;
            ST_XLATE: begin
                if (tlb_hit) state_nx = last_step ? ST_RESP : ST_GREQ;
                else         state_nx = ST_NREQ;
            end
            ST_NREQ:  if (mem_req_ready) state_nx = ST_NWAIT;
            ST_NWAIT: begin
                if (mem_rsp_valid) begin
                    if (!ent_ok)              state_nx = ST_RESP;
                    else if (nlvl_q == '0)    state_nx = last_step ? ST_RESP : ST_GREQ;
                    else                      state_nx = ST_NREQ;
                end
            end
            ST_GREQ:  if (mem_req_ready) state_nx = ST_GWAIT;
            ST_GWAIT: begin
                if (mem_rsp_valid) state_nx = ent_ok ? ST_XLATE : ST_RESP;
            end
            ST_RESP:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gva_q   <= '0;
            gbase_q <= '0;
            hroot_q <= '0;
            gstep_q <= '0;
            nlvl_q  <= '0;
            nbase_q <= '0;
            hpage_q <= '0;
            hpa_q   <= '0;
            fault_q <= 1'b0;
            fdim_q  <= 1'b0;
            flvl_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        gva_q   <= req_gva;
                        gbase_q <= guest_root[PA_W-1:PG_W];
                        hroot_q <= host_root[PA_W-1:PG_W];
                        gstep_q <= '0;
                        hpa_q   <= '0;
                        fault_q <= 1'b0;
                        fdim_q  <= 1'b0;
                        flvl_q  <= '0;
                    end
                end
                ST_XLATE: begin
                    if (tlb_hit) begin
                        hpage_q <= tlb_data;
                        if (last_step) hpa_q <= {tlb_data, gva_q[PG_W-1:0]};
                    end else begin
                        nlvl_q  <= LVL_W'(LEVELS - 1);
                        nbase_q <= hroot_q;
                    end
                end
                ST_NWAIT: begin
                    if (mem_rsp_valid) begin
                        if (!ent_ok) begin
                            fault_q <= 1'b1;
                            fdim_q  <= 1'b1;
                            flvl_q  <= nlvl_q;
                        end else if (nlvl_q == '0) begin
                            hpage_q <= ent_pg;
                            if (last_step) hpa_q <= {ent_pg, gva_q[PG_W-1:0]};
                        end else begin
                            nbase_q <= ent_pg;
                            nlvl_q  <= nlvl_q - 1'b1;
                        end
                    end
                end
                ST_GWAIT: begin
                    if (mem_rsp_valid) begin
                        if (!ent_ok) begin
                            fault_q <= 1'b1;
                            fdim_q  <= 1'b0;
                            flvl_q  <= LVL_W'(LEVELS - 1) - gstep_q[LVL_W-1:0];
                        end else begin
                            gbase_q <= ent_pg;
                            gstep_q <= gstep_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready        = (state == ST_IDLE);
        mem_req_valid    = (state == ST_NREQ) || (state == ST_GREQ);
        mem_req_addr     = (state == ST_NREQ) ? nrd_addr : grd_addr;
        rsp_valid        = (state == ST_RESP);
        rsp_hpa          = hpa_q;
        rsp_fault        = fault_q;
        rsp_fault_nested = fdim_q;
        rsp_fault_level  = flvl_q;
    end

    // read budget counter for the checks below
    logic [RDC_W-1:0] rd_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                          rd_cnt <= '0;
        else if (req_valid && req_ready)     rd_cnt <= '0;
        else if (mem_req_valid && mem_req_ready) rd_cnt <= rd_cnt + 1'b1;
    end

    // R2
    read_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |-> (int'(rd_cnt) < MAX_RD));

    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ntlb |=> !tlb_hit);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R6
    fault_no_hpa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_hpa == '0));

endmodule

// File: tb/nested_walker_tb.sv
module nested_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_task = 1'b0;
    logic        flush_sync = 1'b0;
    logic        flush_ntlb;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_gva = '0;
    logic [47:0] guest_root = '0;
    logic [47:0] host_root = '0;
    logic        rsp_valid;
    logic [47:0] rsp_hpa;
    logic        rsp_fault;
    logic        rsp_fault_nested;
    logic [1:0]  rsp_fault_level;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [47:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    assign flush_ntlb = flush_task | flush_sync;

    always #5 clk = ~clk;

    nested_walker u_dut (
        .clk(clk), .rst_n(rst_n), .flush_ntlb(flush_ntlb),
        .req_valid(req_valid), .req_ready(req_ready), .req_gva(req_gva),
        .guest_root(guest_root), .host_root(host_root),
        .rsp_valid(rsp_valid), .rsp_hpa(rsp_hpa), .rsp_fault(rsp_fault),
        .rsp_fault_nested(rsp_fault_nested), .rsp_fault_level(rsp_fault_level),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [47:0] fault_addr = '1;
    logic [47:0] exp_addr [32];
    logic [47:0] act_addr [32];
    logic [47:0] clean_addr [32];
    int          rd_n = 0;
    int          sync_at = 0;
    bit          stall_mode = 1'b0;
    int          cyc = 0;
    bit          pend = 1'b0;
    logic [47:0] pend_addr = '0;

    // walk results
    int          got_n;
    logic [47:0] got_hpa;
    logic        got_flt, got_dim;
    logic [1:0]  got_lvl;
    bit          busy_ok;
    bit          pulse_ok;

    function automatic logic [63:0] memf(input logic [47:0] a);
        logic [63:0] t;
        t = {16'b0, a} * 64'h9E3779B97F4A7C15;
        return {16'b0, t[63:28], 11'b0, (a != fault_addr)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model: entries hashed from their address
    always @(negedge clk) begin
        cyc++;
        if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = memf(pend_addr);
            flush_sync    = (sync_at != 0) && (sync_at == rd_n);
            pend          = 1'b0;
        end else begin
            mem_rsp_valid = 1'b0;
            flush_sync    = 1'b0;
        end
        mem_req_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
        if (mem_req_valid && mem_req_ready) begin
            pend      = 1'b1;
            pend_addr = mem_req_addr;
            if (rd_n < 32) act_addr[rd_n] = mem_req_addr;
            rd_n++;
        end
    end

    task automatic ref_walk(input logic [47:0] gva, output int n, output logic flt,
                            output logic dim, output logic [1:0] lvl, output logic [47:0] hpa);
        logic [47:0] gbase, nbase, gpa, a;
        logic [63:0] d;
        gbase = guest_root; n = 0; flt = 0; dim = 0; lvl = 0; hpa = 0;
        for (int s = 0; s < 5; s++) begin
            if (s < 4) gpa = {gbase[47:12], gva[12 + 9*(3-s) +: 9], 3'b000};
            else       gpa = {gbase[47:12], gva[11:0]};
            nbase = host_root;
            for (int l = 3; l >= 0; l--) begin
                a = {nbase[47:12], gpa[12 + 9*l +: 9], 3'b000};
                exp_addr[n] = a; n++;
                d = memf(a);
                if (!d[0]) begin flt = 1; dim = 1; lvl = 2'(l); return; end
                nbase = d[47:0];
            end
            if (s == 4) hpa = {nbase[47:12], gva[11:0]};
            else begin
                a = {nbase[47:12], gpa[11:0]};
                exp_addr[n] = a; n++;
                d = memf(a);
                if (!d[0]) begin flt = 1; dim = 0; lvl = 2'(3 - s); return; end
                gbase = d[47:0];
            end
        end
    endtask

    task automatic do_flush();
        @(negedge clk); flush_task = 1'b1;
        @(negedge clk); flush_task = 1'b0;
    endtask

    task automatic do_walk(input logic [47:0] gva);
        int tmo;
        @(negedge clk);
        rd_n = 0; req_valid = 1'b1; req_gva = gva;
        @(negedge clk);
        req_valid = 1'b0;
        busy_ok = 1'b1;
        tmo = 0;
        while (!rsp_valid && tmo < 3000) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk); tmo++;
        end
        if (!rsp_valid) chk(1'b0, "R10 walk timeout", 0, 1);
        got_n = rd_n; got_hpa = rsp_hpa; got_flt = rsp_fault;
        got_dim = rsp_fault_nested; got_lvl = rsp_fault_level;
        @(negedge clk);
        pulse_ok = !rsp_valid && req_ready;
    endtask

    initial begin
        repeat (3000 * 50) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int en, mism;
        logic ef, ed;
        logic [1:0] el;
        logic [47:0] eh, g, g2;

        repeat (3) @(negedge clk);
        // R1
        chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 0);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 0);
        rst_n = 1'b1;
        guest_root = 48'h0123_4567_8000;
        host_root  = 48'h0FED_CBA9_8000;

        for (int i = 0; i < 12; i++) begin
            g = {9'(i * 37 + 5), 9'(i * 91 + 2), 9'(i * 13 + 300), 9'(i * 7 + 1), 12'(i * 273 + 8)};
            do_flush();
            do_walk(g);
            ref_walk(g, en, ef, ed, el, eh);
            chk(got_n == 24, "R2 cold read count", 64'(got_n), 24);
            mism = 0;
            for (int k = 0; k < 24; k++) if (act_addr[k] !== exp_addr[k]) mism++;
            chk(mism == 0, "R3 R4 read address sequence", 64'(mism), 0);
            chk(got_hpa == eh && !got_flt, "R5 translated address", 64'(got_hpa), 64'(eh));
            chk(busy_ok && pulse_ok, "R10 busy and pulse", 64'({busy_ok, pulse_ok}), 3);
            do_walk(g);
            chk(got_n == 4, "R7 warm read count", 64'(got_n), 4);
            chk(got_hpa == eh, "R7 warm address", 64'(got_hpa), 64'(eh));
            g2 = {g[47:12], 12'(g[11:0] ^ 12'hA5C)};
            do_walk(g2);
            chk(got_n == 4 && got_hpa == {eh[47:12], g2[11:0]}, "R7 R5 offset variant",
                64'(got_hpa), 64'({eh[47:12], g2[11:0]}));
        end

        // R8
        g = 48'h1357_9BDF_0246;
        do_walk(g);
        do_flush();
        do_walk(g);
        chk(got_n == 24, "R8 flush restores full walk", 64'(got_n), 24);

        // R6 fault sweep over every read position, then again with back-pressure
        do_flush();
        do_walk(g);
        for (int k = 0; k < 24; k++) clean_addr[k] = act_addr[k];
        for (int pass = 0; pass < 2; pass++) begin
            stall_mode = (pass == 1);
            for (int p = 0; p < 24; p++) begin
                int grp, r;
                logic xd;
                logic [1:0] xl;
                grp = p / 5; r = p % 5;
                if (p >= 20)   begin xd = 1'b1; xl = 2'(3 - (p - 20)); end
                else if (r < 4) begin xd = 1'b1; xl = 2'(3 - r); end
                else            begin xd = 1'b0; xl = 2'(3 - grp); end
                fault_addr = clean_addr[p];
                do_flush();
                do_walk(g);
                chk(got_n == p + 1, "R6 reads stop at fault", 64'(got_n), 64'(p + 1));
                chk(got_flt && got_hpa == 0, "R6 fault flag", 64'(got_hpa), 0);
                chk(got_dim == xd && got_lvl == xl, "R6 dimension and level",
                    64'({got_dim, got_lvl}), 64'({xd, xl}));
                if (pass == 1) begin
                    mism = 0;
                    for (int k = 0; k <= p; k++) if (act_addr[k] !== clean_addr[k]) mism++;
                    chk(mism == 0, "R11 addresses under back-pressure", 64'(mism), 0);
                end
            end
        end
        fault_addr = '1;
        stall_mode = 1'b0;

        // R9 flush in the cycle of the first fill
        do_flush();
        sync_at = 4;
        do_walk(g);
        sync_at = 0;
        chk(got_n == 24, "R9 walk with coincident flush", 64'(got_n), 24);
        do_walk(g);
        chk(got_n == 8, "R9 dropped fill re-walked", 64'(got_n), 8);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule